// File: doc/BRIEF.md
# Watermark Pause-Frame Request Generator

This block watches how much room is left in a receive buffer and asks the transmit MAC to send IEEE 802.3x flow-control frames. When free space falls below a high watermark, it requests a frame that stops the link partner, with a pause time of FFFFh (XOFF). When free space later rises above a low watermark, it requests a frame that lets the partner resume, with a pause time of 0000h (XON). Both watermarks arrive as 4-bit fields in 1 KB units. The gap between the two watermarks gives hysteresis.

The block is a four-state machine with the states idle, XOFF pending, paused and XON pending. A request is held until the transmitter acknowledges it. The XON request can only come after the transmitter has acknowledged the XOFF request. While the block is paused it raises no second XOFF request. Building the frame and computing its CRC are left to the transmitter.

Top module: `pause_watermark_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pause_req` is 0 and the machine is idle.
- R2: When idle with a non-zero high threshold, free space strictly less than `hw_kb`×1024 raises `pause_req` after the next rising clock edge, with `pause_time` = FFFFh.
- R3: When `hw_kb` is 0, only a free space of exactly 0 bytes raises the XOFF request.
- R4: Once `pause_req` is 1, it stays 1 and `pause_time` stays unchanged until an edge at which `tx_ack` is 1. After that edge `pause_req` is 0.
- R5: After an XOFF request has been acknowledged, no further FFFFh request is raised while free space stays at or below `lw_kb`×1024, even when it is below the high threshold.
- R6: After an acknowledged XOFF, free space strictly greater than `lw_kb`×1024 raises `pause_req` after the next edge, with `pause_time` = 0000h.
- R7: `pause_time` never reads 0000h while `pause_req` is 1 unless an XOFF was acknowledged before it. A pending XOFF keeps FFFFh even when free space climbs above the low threshold.
- R8: `tx_ack` while `pause_req` is 0 has no effect: the outputs and the next request behave as if it had been 0.
- R9: An acknowledge that arrives together with the watermark condition for the opposite frame leaves exactly one cycle with `pause_req` at 0. The opposite request is raised in the cycle after that.
- R10: Equality does not trigger: free space equal to `hw_kb`×1024 raises no XOFF, and free space equal to `lw_kb`×1024 raises no XON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| free_bytes | input | 16 | Free receive-buffer space in bytes |
| hw_kb | input | 4 | High watermark, in 1 KB units |
| lw_kb | input | 4 | Low watermark, in 1 KB units |
| tx_ack | input | 1 | Transmitter has accepted the current request |
| pause_req | output | 1 | Request to send a pause frame |
| pause_time | output | 16 | Pause time for the requested frame |

## Verification
The two functions that can fall in one cycle are the acknowledge of a pending frame and the watermark condition for the opposite frame. The bench provokes this in both directions. First it holds free space above the low watermark at the edge where the XOFF is acknowledged. Then it holds free space below the high watermark at the edge where the XON is acknowledged. The bench judges each case by checking for a single cycle with `pause_req` at 0, followed by the opposite pause time. A separate case acknowledges with no request pending and expects no change.

// File: rtl/pause_pkg.sv
package pause_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_XOFF_PEND = 2'd1,
    ST_PAUSED    = 2'd2,
    ST_XON_PEND  = 2'd3
  } pause_st_e;

  localparam int unsigned PT_W = 16;
  localparam logic [PT_W-1:0] PT_XOFF = 16'hFFFF;
  localparam logic [PT_W-1:0] PT_XON  = 16'h0000;
endpackage

// File: rtl/pause_wm_compare.sv
module pause_wm_compare #(
  parameter int unsigned FREE_W   = 16,
  parameter int unsigned TH_W     = 4,
  parameter int unsigned KB_SHIFT = 10
) (
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [TH_W-1:0]   hw_kb,
  input  logic [TH_W-1:0]   lw_kb,
  output logic              below_hi,
  output logic              above_lo
);
  localparam int unsigned LIM_W = TH_W + KB_SHIFT;
  localparam int unsigned CMP_W = (LIM_W > FREE_W) ? LIM_W : FREE_W;

  // Watermark in bytes, widened so that the shift never truncates
  function automatic logic [CMP_W-1:0] kb_to_bytes(input logic [TH_W-1:0] th);
    kb_to_bytes = CMP_W'(th) << KB_SHIFT;
  endfunction

  logic [CMP_W-1:0] free_w;
  logic [CMP_W-1:0] hi_lim;
  logic [CMP_W-1:0] lo_lim;

  assign free_w = CMP_W'(free_bytes);
  assign hi_lim = kb_to_bytes(hw_kb);
  assign lo_lim = kb_to_bytes(lw_kb);

  // A zero high watermark means the buffer must be completely full
  always_comb begin
    if (hw_kb == '0) below_hi = (free_w == '0);
    else             below_hi = (free_w < hi_lim);
  end

  assign above_lo = (free_w > lo_lim);
endmodule

// File: rtl/pause_hyst_fsm.sv
module pause_hyst_fsm
  import pause_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            below_hi,
  input  logic            above_lo,
  input  logic            tx_ack,
  output logic            pause_req,
  output logic [PT_W-1:0] pause_time,
  output pause_st_e       state_o
);
  pause_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (below_hi) state_d = ST_XOFF_PEND;
      ST_XOFF_PEND: if (tx_ack)   state_d = ST_PAUSED;
      ST_PAUSED:    if (above_lo) state_d = ST_XON_PEND;
      ST_XON_PEND:  if (tx_ack)   state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign pause_req  = (state_q == ST_XOFF_PEND) || (state_q == ST_XON_PEND);
  assign pause_time = (state_q == ST_XON_PEND) ? PT_XON : PT_XOFF;
  assign state_o    = state_q;

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req && !tx_ack |=> pause_req && $stable(pause_time));

  assert_drop_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req && tx_ack |=> !pause_req);

  assert_xoff_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && below_hi |=> pause_req && (pause_time == PT_XOFF));

  assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && !below_hi && tx_ack |=> !pause_req);
endmodule

// File: rtl/pause_watermark_gen.sv
module pause_watermark_gen
  import pause_pkg::*;
#(
  parameter int unsigned FREE_W   = 16,
  parameter int unsigned TH_W     = 4,
  parameter int unsigned KB_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [TH_W-1:0]   hw_kb,
  input  logic [TH_W-1:0]   lw_kb,
  input  logic              tx_ack,
  output logic              pause_req,
  output logic [PT_W-1:0]   pause_time
);
  logic      below_hi;
  logic      above_lo;
  pause_st_e fsm_state;

  pause_wm_compare #(
    .FREE_W  (FREE_W),
    .TH_W    (TH_W),
    .KB_SHIFT(KB_SHIFT)
  ) u_cmp (
    .free_bytes(free_bytes),
    .hw_kb     (hw_kb),
    .lw_kb     (lw_kb),
    .below_hi  (below_hi),
    .above_lo  (above_lo)
  );

  pause_hyst_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .below_hi  (below_hi),
    .above_lo  (above_lo),
    .tx_ack    (tx_ack),
    .pause_req (pause_req),
    .pause_time(pause_time),
    .state_o   (fsm_state)
  );

  // Observer: remembers whether the most recent acknowledged frame was XOFF
  logic xoff_acked;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  xoff_acked <= 1'b0;
    else if (pause_req && tx_ack) xoff_acked <= (pause_time == PT_XOFF);
  end

  assert_xon_after_xoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) && (pause_time == PT_XON) |-> xoff_acked);

  assert_no_repeat_xoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) && (pause_time == PT_XOFF) |-> !xoff_acked);

  assert_paused_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_PAUSED) && !above_lo |=> !pause_req);
endmodule

// File: tb/pause_watermark_gen_tb.sv
module pause_watermark_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] free_bytes = 16'd20000;
  logic [3:0]  hw_kb = 4'd3;
  logic [3:0]  lw_kb = 4'd8;
  logic        tx_ack = 1'b0;
  logic        pause_req;
  logic [15:0] pause_time;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pause_watermark_gen u_dut (
    .clk(clk), .rst_n(rst_n), .free_bytes(free_bytes), .hw_kb(hw_kb),
    .lw_kb(lw_kb), .tx_ack(tx_ack), .pause_req(pause_req), .pause_time(pause_time)
  );

  // Row: free_bytes, tx_ack, expected pause_req, expected pause_time (hw=3 KB, lw=8 KB)
  localparam int NV = 17;
  localparam logic [33:0] VEC [NV] = '{
    {16'd20000, 1'b0, 1'b0, 16'hFFFF}, // R1 idle after reset
    {16'd3072,  1'b0, 1'b0, 16'hFFFF}, // R10 equal to high mark
    {16'd3071,  1'b0, 1'b1, 16'hFFFF}, // R2 XOFF raised
    {16'd20000, 1'b0, 1'b1, 16'hFFFF}, // R7 pending XOFF keeps FFFF
    {16'd20000, 1'b1, 1'b0, 16'hFFFF}, // R4 drop after ack
    {16'd1000,  1'b0, 1'b0, 16'hFFFF}, // R5 no repeat XOFF
    {16'd1000,  1'b0, 1'b0, 16'hFFFF}, // R5 still quiet
    {16'd8192,  1'b0, 1'b0, 16'hFFFF}, // R10 equal to low mark
    {16'd8193,  1'b0, 1'b1, 16'h0000}, // R6 XON raised
    {16'd8193,  1'b0, 1'b1, 16'h0000}, // R4 held
    {16'd8193,  1'b1, 1'b0, 16'hFFFF}, // R4 acked
    {16'd8193,  1'b1, 1'b0, 16'hFFFF}, // R8 stray ack ignored
    {16'd2000,  1'b0, 1'b1, 16'hFFFF}, // R2 XOFF again
    {16'd9000,  1'b1, 1'b0, 16'hFFFF}, // R9 ack with release condition
    {16'd9000,  1'b0, 1'b1, 16'h0000}, // R9 XON one cycle later
    {16'd100,   1'b1, 1'b0, 16'hFFFF}, // R9 ack with congestion
    {16'd100,   1'b0, 1'b1, 16'hFFFF}  // R9 XOFF one cycle later
  };

  task automatic check(input string tag, input logic req_exp, input logic [15:0] t_exp);
    total++;
    if (pause_req !== req_exp || (req_exp && pause_time !== t_exp)) begin
      bad++;
      $display("FAIL %s: req=%0b time=%h expected req=%0b time=%h",
               tag, pause_req, pause_time, req_exp, t_exp);
    end
  endtask

  task automatic step(input logic [15:0] f, input logic a);
    @(negedge clk);
    free_bytes = f;
    tx_ack = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1 check("R1 in reset", 1'b0, 16'hFFFF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33:18], VEC[i][17]);
      check($sformatf("vector %0d", i), VEC[i][16], VEC[i][15:0]);
    end
    // R1: reset clears a pending request
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 reset mid-request", 1'b0, 16'hFFFF);
    hw_kb = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;
    // R3: zero high mark only fires on a full buffer
    step(16'd1, 1'b0);
    check("R3 hw=0 free=1", 1'b0, 16'hFFFF);
    step(16'd0, 1'b0);
    check("R3 hw=0 free=0", 1'b1, 16'hFFFF);
    step(16'd0, 1'b0);
    check("R4 hold with hw=0", 1'b1, 16'hFFFF);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule